// File: doc/BRIEF.md
# Disk Sector Address Encoder

This block turns a linear sector number into the byte values a host writes into the task-file registers of a disk drive to read that single sector. It supports three encodings. The first is cylinder/head/sector, built from the drive geometry. The second is 28-bit logical addressing and the third is 48-bit logical addressing. For each request it produces these bytes:
- the sector count;
- a low, mid and high address byte;
- a second, higher-order set of low, mid and high address bytes;
- the device byte;
- the command opcode.

The surrounding logic starts a conversion with a one-cycle pulse and waits for a one-cycle done pulse. After that pulse it reads the registered bytes, or the range-error flag.

The logical modes finish at the edge that samples the request. The cylinder/head/sector mode performs two divisions: first sector / sectors-per-track, then track / heads. Both run one after the other on a single restoring shift-subtract divider that resolves one quotient bit per clock. Placing the bytes on a drive bus is left to other logic.

Top module: `sector_addr_encoder`

## Requirements
- R1: The mode input selects the encoding: 0 = cylinder/head/sector, 1 = 28-bit logical, 2 = 48-bit logical. Mode 3 completes with range_err = 1.
- R2: In mode 0, track = sector / spt and cylinder = track / heads. addr_lo = 1 + (sector mod spt), in its low 8 bits. addr_mid = cylinder[7:0] and addr_hi = cylinder[15:8]. The three extended address bytes are 0.
- R3: In mode 0, device = 0xA0 OR (slave ? 0x10 : 0) OR ((track mod heads) AND 0xF), so bit 6 is 0. The command is 0x20.
- R4: In mode 1, addr_lo, addr_mid and addr_hi carry sector bits [7:0], [15:8] and [23:16]. device = 0xE0 OR (slave ? 0x10 : 0) OR sector[27:24]. The extended bytes are 0 and the command is 0x20.
- R5: In mode 2, the low, mid and high bytes carry sector bits [7:0], [15:8] and [23:16]. The extended low, mid and high bytes carry bits [31:24], [39:32] and [47:40]. device = 0x40 OR (slave ? 0x10 : 0), with bit 7 clear, and the command is 0x24.
- R6: Every request that completes without error reports sec_count = 1.
- R7: A sector number greater than total completes with range_err = 1 and all nine task-file bytes 0. A sector number equal to total is encoded normally.
- R8: In mode 0, a heads or spt value of zero completes with range_err = 1 and no division is performed. In modes 1 and 2 the geometry has no effect.
- R9: Edge 0 is the edge that samples start. In modes 1 and 2, and for every error, done is high after edge 0. A mode 0 conversion raises done after edge 2*SECT_W+2.
- R10: done is a one-cycle pulse for each request. All task-file outputs and range_err change only at an edge that raises done, and hold their values otherwise.
- R11: A start pulse that arrives while a mode 0 conversion is running is ignored. It produces no done pulse and leaves the running result unchanged.
- R12: A start sampled in the cycle where done is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| mode | input | 2 | Address encoding select |
| sector | input | SECT_W | Linear sector number |
| heads | input | GEO_W | Heads per cylinder |
| spt | input | GEO_W | Sectors per track |
| slave | input | 1 | Selects the second drive on the channel |
| total | input | SECT_W | Highest accepted sector number |
| sec_count | output | 8 | Sector count byte |
| addr_lo | output | 8 | Low address byte (sector number in mode 0) |
| addr_mid | output | 8 | Mid address byte (cylinder low in mode 0) |
| addr_hi | output | 8 | High address byte (cylinder high in mode 0) |
| addr_lo_ext | output | 8 | Second low address byte |
| addr_mid_ext | output | 8 | Second mid address byte |
| addr_hi_ext | output | 8 | Second high address byte |
| device | output | 8 | Device/head byte |
| command | output | 8 | Command opcode |
| range_err | output | 1 | Request rejected |
| done | output | 1 | Result valid pulse |

## Verification
The closest collision is a new request arriving in the cycle that still carries the previous conversion's done pulse, at the moment the controller returns to idle. The bench forces this by raising start at the very sample where it first sees done from a long mode 0 conversion. It then requires a second done in the next cycle, with the fresh logical result replacing the old bytes. A related overlap, a start that arrives while the divider is mid-run, is judged by checking that only one done appears, at the unchanged mode 0 latency, carrying the first request's bytes.

// File: rtl/sae_pkg.sv
package sae_pkg;

  typedef enum logic [1:0] {
    MODE_CHS   = 2'd0,
    MODE_LBA28 = 2'd1,
    MODE_LBA48 = 2'd2
  } addr_mode_e;

  localparam int         ADDR48_W     = 48;
  localparam logic [7:0] CMD_READ     = 8'h20;
  localparam logic [7:0] CMD_READ_EXT = 8'h24;
  localparam logic [7:0] DEV_LEGACY   = 8'hA0;
  localparam logic [7:0] DEV_LBA      = 8'h40;
  localparam logic [7:0] DEV_SLAVE    = 8'h10;

  typedef struct packed {
    logic [7:0] count;
    logic [7:0] lo;
    logic [7:0] mid;
    logic [7:0] hi;
    logic [7:0] lo2;
    logic [7:0] mid2;
    logic [7:0] hi2;
    logic [7:0] dev;
    logic [7:0] cmd;
  } taskfile_t;

endpackage

// File: rtl/sae_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
// A start pulse loads the operands; fin pulses in the cycle after the last step.
module sae_divider #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem,
  output logic             fin
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] r_r;
  logic [CNT_W-1:0] cnt_r;
  logic             run_r;
  logic             fin_r;

  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;
  logic             ge;

  always_comb begin
    shifted = {r_r, q_r[NUM_W-1]};
    ge      = shifted >= {1'b0, den_q};
    trial   = shifted - {1'b0, den_q};
  end

  logic [DEN_W-1:0] den_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      r_r   <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      fin_r <= 1'b0;
      den_q <= '0;
    end else begin
      fin_r <= 1'b0;
      if (start) begin
        q_r   <= num;
        r_r   <= '0;
        den_q <= den;
        cnt_r <= CNT_W'(NUM_W);
        run_r <= 1'b1;
      end else if (run_r) begin
        q_r   <= {q_r[NUM_W-2:0], ge};
        r_r   <= ge ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNT_W'(1)) begin
          run_r <= 1'b0;
          fin_r <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
  assign rem = r_r;
  assign fin = fin_r;

endmodule

// File: rtl/sae_lba_pack.sv
// Formats the task-file bytes for the two logical-address encodings.
module sae_lba_pack
  import sae_pkg::*;
#(
  parameter int SECT_W = 48
) (
  input  logic              wide,
  input  logic [SECT_W-1:0] sector,
  input  logic              slave,
  output taskfile_t         tf
);
  localparam int EXT_W = (SECT_W > ADDR48_W) ? SECT_W : ADDR48_W;

  logic [EXT_W-1:0] s;
  logic [7:0]       sel;

  always_comb begin
    s   = EXT_W'(sector);
    sel = slave ? DEV_SLAVE : 8'h00;
    tf       = '0;
    tf.count = 8'h01;
    tf.lo    = s[7:0];
    tf.mid   = s[15:8];
    tf.hi    = s[23:16];
    if (wide) begin
      tf.lo2 = s[31:24];
      tf.mid2 = s[39:32];
      tf.hi2 = s[47:40];
      tf.dev = DEV_LBA | sel;
      tf.cmd = CMD_READ_EXT;
    end else begin
      tf.dev = DEV_LEGACY | DEV_LBA | sel | {4'h0, s[27:24]};
      tf.cmd = CMD_READ;
    end
  end

endmodule

// File: rtl/sae_chs_pack.sv
// Formats the task-file bytes from the two division results.
module sae_chs_pack
  import sae_pkg::*;
#(
  parameter int SECT_W = 48,
  parameter int GEO_W  = 16
) (
  input  logic [SECT_W-1:0] cyl,
  input  logic [GEO_W-1:0]  head_rem,
  input  logic [GEO_W-1:0]  sect_rem,
  input  logic              slave,
  output taskfile_t         tf
);
  logic [GEO_W-1:0] sect_one;

  always_comb begin
    sect_one = sect_rem + GEO_W'(1);
    tf       = '0;
    tf.count = 8'h01;
    tf.lo    = sect_one[7:0];
    tf.mid   = cyl[7:0];
    tf.hi    = cyl[15:8];
    tf.dev   = DEV_LEGACY | (slave ? DEV_SLAVE : 8'h00) | {4'h0, head_rem[3:0]};
    tf.cmd   = CMD_READ;
  end

endmodule

// File: rtl/sector_addr_encoder.sv
module sector_addr_encoder
  import sae_pkg::*;
#(
  parameter int SECT_W = 48,
  parameter int GEO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [SECT_W-1:0] sector,
  input  logic [GEO_W-1:0]  heads,
  input  logic [GEO_W-1:0]  spt,
  input  logic              slave,
  input  logic [SECT_W-1:0] total,
  output logic [7:0]        sec_count,
  output logic [7:0]        addr_lo,
  output logic [7:0]        addr_mid,
  output logic [7:0]        addr_hi,
  output logic [7:0]        addr_lo_ext,
  output logic [7:0]        addr_mid_ext,
  output logic [7:0]        addr_hi_ext,
  output logic [7:0]        device,
  output logic [7:0]        command,
  output logic              range_err,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_TRACK, ST_CYL} state_e;

  state_e            st;
  taskfile_t         tf_q;
  logic              err_q;
  logic              done_q;
  logic [GEO_W-1:0]  heads_q;
  logic [GEO_W-1:0]  sect_rem_q;
  logic              slave_q;

  logic              accept;
  logic              mode_ok;
  logic              range_bad;
  logic              geo_bad;
  logic              req_bad;
  logic              chs_go;

  logic              div_go;
  logic [SECT_W-1:0] div_num;
  logic [GEO_W-1:0]  div_den;
  logic [SECT_W-1:0] div_quo;
  logic [GEO_W-1:0]  div_rem;
  logic              div_fin;

  taskfile_t         lba_tf;
  taskfile_t         chs_tf;

  always_comb begin
    accept    = (st == ST_IDLE) && start;
    mode_ok   = (mode == MODE_CHS) || (mode == MODE_LBA28) || (mode == MODE_LBA48);
    range_bad = sector > total;
    geo_bad   = (mode == MODE_CHS) && ((heads == '0) || (spt == '0));
    req_bad   = !mode_ok || range_bad || geo_bad;
    chs_go    = accept && !req_bad && (mode == MODE_CHS);
    div_go    = chs_go || ((st == ST_TRACK) && div_fin);
    div_num   = (st == ST_IDLE) ? sector : div_quo;
    div_den   = (st == ST_IDLE) ? spt : heads_q;
  end

  sae_divider #(
    .NUM_W (SECT_W),
    .DEN_W (GEO_W)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go),
    .num   (div_num),
    .den   (div_den),
    .quo   (div_quo),
    .rem   (div_rem),
    .fin   (div_fin)
  );

  sae_lba_pack #(
    .SECT_W (SECT_W)
  ) u_lba (
    .wide   (mode == MODE_LBA48),
    .sector (sector),
    .slave  (slave),
    .tf     (lba_tf)
  );

  sae_chs_pack #(
    .SECT_W (SECT_W),
    .GEO_W  (GEO_W)
  ) u_chs (
    .cyl      (div_quo),
    .head_rem (div_rem),
    .sect_rem (sect_rem_q),
    .slave    (slave_q),
    .tf       (chs_tf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tf_q       <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      heads_q    <= '0;
      sect_rem_q <= '0;
      slave_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (req_bad) begin
              tf_q   <= '0;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else if (mode == MODE_CHS) begin
              heads_q <= heads;
              slave_q <= slave;
              st      <= ST_TRACK;
            end else begin
              tf_q   <= lba_tf;
              err_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        ST_TRACK: begin
          if (div_fin) begin
            sect_rem_q <= div_rem;
            st         <= ST_CYL;
          end
        end
        ST_CYL: begin
          if (div_fin) begin
            tf_q   <= chs_tf;
            err_q  <= 1'b0;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sec_count    = tf_q.count;
  assign addr_lo      = tf_q.lo;
  assign addr_mid     = tf_q.mid;
  assign addr_hi      = tf_q.hi;
  assign addr_lo_ext  = tf_q.lo2;
  assign addr_mid_ext = tf_q.mid2;
  assign addr_hi_ext  = tf_q.hi2;
  assign device       = tf_q.dev;
  assign command      = tf_q.cmd;
  assign range_err    = err_q;
  assign done         = done_q;

endmodule

// File: rtl/sae_checker.sv
module sae_checker #(
  parameter int SECT_W = 48,
  parameter int GEO_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        mode,
  input logic [SECT_W-1:0] sector,
  input logic [GEO_W-1:0]  heads,
  input logic [GEO_W-1:0]  spt,
  input logic [SECT_W-1:0] total,
  input logic [7:0]        sec_count,
  input logic [7:0]        addr_lo,
  input logic [7:0]        addr_mid,
  input logic [7:0]        addr_hi,
  input logic [7:0]        addr_lo_ext,
  input logic [7:0]        addr_mid_ext,
  input logic [7:0]        addr_hi_ext,
  input logic [7:0]        device,
  input logic [7:0]        command,
  input logic              range_err,
  input logic              done
);
  localparam int LAT   = 2 * SECT_W + 2;
  localparam int LCW   = $clog2(LAT + 2);

  logic           past_ok;
  logic           busy;
  logic [LCW-1:0] lat_cnt;
  logic           took;
  logic           long_path;
  logic [71:0]    bytes;

  always_comb begin
    took      = start && (!busy || done);
    long_path = (mode == 2'd0) && (heads != '0) && (spt != '0) && (sector <= total);
    bytes     = {sec_count, addr_lo, addr_mid, addr_hi, addr_lo_ext,
                 addr_mid_ext, addr_hi_ext, device, command};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      busy    <= 1'b0;
      lat_cnt <= '0;
    end else begin
      past_ok <= 1'b1;
      if (took && long_path) begin
        busy    <= 1'b1;
        lat_cnt <= '0;
      end else if (busy) begin
        if (done) busy <= 1'b0;
        lat_cnt <= lat_cnt + 1'b1;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> ($stable(bytes) && $stable(range_err)));

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (done && range_err) |-> (bytes == '0));

  assert_count_one_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !range_err) |-> (sec_count == 8'h01));

  assert_ext_opcode_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !range_err) |-> ((command == 8'h24) == (device[7] == 1'b0)));

  assert_bad_mode_R1: assert property (@(posedge clk) disable iff (rst)
    (took && mode == 2'd3) |=> (done && range_err));

  assert_short_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (took && !long_path) |=> done);

  assert_long_early_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |-> (lat_cnt == LCW'(LAT)));

endmodule

bind sector_addr_encoder sae_checker #(
  .SECT_W (SECT_W),
  .GEO_W  (GEO_W)
) u_sae_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .mode         (mode),
  .sector       (sector),
  .heads        (heads),
  .spt          (spt),
  .total        (total),
  .sec_count    (sec_count),
  .addr_lo      (addr_lo),
  .addr_mid     (addr_mid),
  .addr_hi      (addr_hi),
  .addr_lo_ext  (addr_lo_ext),
  .addr_mid_ext (addr_mid_ext),
  .addr_hi_ext  (addr_hi_ext),
  .device       (device),
  .command      (command),
  .range_err    (range_err),
  .done         (done)
);

// File: tb/sector_addr_encoder_test.sv
module sector_addr_encoder_test;
  localparam int SECT_W = 48;
  localparam int GEO_W  = 16;
  localparam int LONG_LAT = 2 * SECT_W + 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        mode = '0;
  logic [SECT_W-1:0] sector = '0;
  logic [GEO_W-1:0]  heads = '0;
  logic [GEO_W-1:0]  spt = '0;
  logic              slave = 1'b0;
  logic [SECT_W-1:0] total = '0;
  logic [7:0] sec_count, addr_lo, addr_mid, addr_hi, addr_lo_ext, addr_mid_ext, addr_hi_ext;
  logic [7:0] device, command;
  logic       range_err, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sector_addr_encoder #(.SECT_W(SECT_W), .GEO_W(GEO_W)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sector(sector),
    .heads(heads), .spt(spt), .slave(slave), .total(total),
    .sec_count(sec_count), .addr_lo(addr_lo), .addr_mid(addr_mid), .addr_hi(addr_hi),
    .addr_lo_ext(addr_lo_ext), .addr_mid_ext(addr_mid_ext), .addr_hi_ext(addr_hi_ext),
    .device(device), .command(command), .range_err(range_err), .done(done)
  );

  function automatic logic [71:0] outs();
    return {sec_count, addr_lo, addr_mid, addr_hi, addr_lo_ext, addr_mid_ext,
            addr_hi_ext, device, command};
  endfunction

  function automatic logic [71:0] exp_chs(longint unsigned s, longint unsigned h,
                                          longint unsigned p, bit sl);
    longint unsigned trk = s / p;
    longint unsigned sn  = 1 + (s % p);
    longint unsigned cyl = trk / h;
    longint unsigned hd  = trk % h;
    return {8'h01, 8'(sn), 8'(cyl), 8'(cyl >> 8), 24'h0,
            8'hA0 | (sl ? 8'h10 : 8'h00) | 8'(hd & 15), 8'h20};
  endfunction

  function automatic logic [71:0] exp_l28(logic [47:0] s, bit sl);
    return {8'h01, s[7:0], s[15:8], s[23:16], 24'h0,
            8'hE0 | (sl ? 8'h10 : 8'h00) | {4'h0, s[27:24]}, 8'h20};
  endfunction

  function automatic logic [71:0] exp_l48(logic [47:0] s, bit sl);
    return {8'h01, s[7:0], s[15:8], s[23:16], s[31:24], s[39:32], s[47:40],
            8'h40 | (sl ? 8'h10 : 8'h00), 8'h24};
  endfunction

  task automatic check(string req, logic [71:0] got, logic [71:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drives one request at a falling edge and returns falling edges until done.
  task automatic req(logic [1:0] m, logic [47:0] s, int h, int p, bit sl,
                     logic [47:0] tot, output int lat);
    mode = m; sector = s; heads = GEO_W'(h); spt = GEO_W'(p); slave = sl; total = tot;
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 400);
  endtask

  task automatic result(string req_tag, int lat, int exp_lat, bit exp_err,
                        logic [71:0] exp);
    check({req_tag, " latency"}, 72'(lat), 72'(exp_lat));
    check({req_tag, " error flag"}, 72'(range_err), 72'(exp_err));
    check({req_tag, " bytes"}, outs(), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [71:0] snap;
    logic [47:0] ALL = 48'hFFFF_FFFF_FFFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state (R10): outputs zero, no done
    check("R10 reset bytes", outs(), '0);
    check("R10 reset done/err", {70'h0, done, range_err}, '0);

    // R2 R3 R9 sweep over small geometries
    for (int h = 1; h <= 4; h++)
      for (int p = 1; p <= 6; p++)
        for (int s = 0; s <= h * p * 2 + 1; s++) begin
          req(2'd0, 48'(s), h, p, s[0], ALL, lat);
          result("R2 R3 R6 R9 chs sweep", lat, LONG_LAT, 1'b0,
                 exp_chs(longint'(s), longint'(h), longint'(p), s[0]));
        end
    // Large geometry, head nibble and cylinder high byte in use
    req(2'd0, 48'd1_000_000, 16, 63, 1'b1, ALL, lat);
    result("R2 R3 chs large", lat, LONG_LAT, 1'b0, exp_chs(1_000_000, 16, 63, 1'b1));
    req(2'd0, 48'd16_514_063, 255, 63, 1'b0, ALL, lat);
    result("R2 R3 chs wide heads", lat, LONG_LAT, 1'b0, exp_chs(16_514_063, 255, 63, 1'b0));

    // R4 R5 walking ones, both drives
    for (int b = 0; b < 48; b++)
      for (int sl = 0; sl < 2; sl++) begin
        logic [47:0] v = 48'h1 << b;
        req(2'd1, v, 0, 0, sl[0], ALL, lat);
        result("R4 R8 lba28 walk", lat, 1, 1'b0, exp_l28(v, sl[0]));
        req(2'd2, v ^ 48'h5A5A_A5A5_0F0F, 3, 0, sl[0], ALL, lat);
        result("R5 lba48 walk", lat, 1, 1'b0, exp_l48(v ^ 48'h5A5A_A5A5_0F0F, sl[0]));
      end

    // R1 invalid mode
    req(2'd3, 48'd5, 2, 2, 1'b0, ALL, lat);
    result("R1 mode 3", lat, 1, 1'b1, '0);

    // R7 boundary: equal accepted, greater rejected
    req(2'd1, 48'd1000, 0, 0, 1'b0, 48'd1000, lat);
    result("R7 lba28 equal total", lat, 1, 1'b0, exp_l28(48'd1000, 1'b0));
    req(2'd1, 48'd1001, 0, 0, 1'b0, 48'd1000, lat);
    result("R7 lba28 above total", lat, 1, 1'b1, '0);
    req(2'd0, 48'd24, 2, 3, 1'b1, 48'd24, lat);
    result("R7 chs equal total", lat, LONG_LAT, 1'b0, exp_chs(24, 2, 3, 1'b1));
    req(2'd0, 48'd25, 2, 3, 1'b1, 48'd24, lat);
    result("R7 chs above total", lat, 1, 1'b1, '0);
    req(2'd2, 48'h8000_0000_0000, 0, 0, 1'b0, 48'h7FFF_FFFF_FFFF, lat);
    result("R7 lba48 above total", lat, 1, 1'b1, '0);

    // R8 zero geometry in CHS
    req(2'd0, 48'd3, 0, 5, 1'b0, ALL, lat);
    result("R8 zero heads", lat, 1, 1'b1, '0);
    req(2'd0, 48'd3, 4, 0, 1'b0, ALL, lat);
    result("R8 zero spt", lat, 1, 1'b1, '0);

    // R10 done is a single pulse and outputs hold
    req(2'd2, 48'h1234_5678_9ABC, 0, 0, 1'b1, ALL, lat);
    snap = outs();
    sector = 48'h0; mode = 2'd1; slave = 1'b0;
    @(negedge clk);
    check("R10 done single pulse", 72'(done), 72'h0);
    repeat (5) @(negedge clk);
    check("R10 hold bytes", outs(), snap);
    check("R10 no spurious done", 72'(done), 72'h0);

    // R11 start during a CHS conversion is ignored
    mode = 2'd0; sector = 48'd777; heads = 16'd5; spt = 16'd17; slave = 1'b0; total = ALL;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 1;
    repeat (10) begin @(negedge clk); lat++; end
    mode = 2'd1; sector = 48'hAB_CDEF; start = 1'b1;
    @(negedge clk); start = 1'b0; lat++;
    check("R11 no done for ignored start", 72'(done), 72'h0);
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    result("R11 chs result kept", lat, LONG_LAT, 1'b0, exp_chs(777, 5, 17, 1'b0));
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 single done", 72'(done), 72'h0);
    check("R11 bytes unchanged", outs(), exp_chs(777, 5, 17, 1'b0));

    // R12 start in the cycle done is high
    req(2'd0, 48'd4321, 3, 11, 1'b1, ALL, lat);
    result("R12 first chs", lat, LONG_LAT, 1'b0, exp_chs(4321, 3, 11, 1'b1));
    req(2'd2, 48'hFEDC_BA98_7654, 0, 0, 1'b0, ALL, lat);
    result("R12 back to back lba48", lat, 1, 1'b0, exp_l48(48'hFEDC_BA98_7654, 1'b0));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule